// File: doc/BRIEF.md
# Slave Serial Audio Transmitter with Internally Derived Bit Clock

This block puts stereo pairs of 24-bit audio words onto one serial data line in I2S format. It never drives a clock. The master clock and the word-select clock both come from outside. The bit clock exists only inside the block: it is counted down from the master clock and restarted on every word-select transition. A host that runs its own bit clock at 64 times the sample rate, aligned to the same word-select edges, can therefore capture the data without a bit-clock wire.

A clock-ratio detector outside the block supplies a select input. When the master clock is 256 times the sample rate, each bit lasts four master-clock cycles. When it is 128 times the sample rate, each bit lasts two. Each half of the word-select period is split into 32 bit slots. The word goes out most significant bit first, starting one slot after the transition, and the unused slots send zero.

A new pair of words is offered with a one-cycle strobe. It takes effect only at the start of the next left half, so a frame never carries a mix of two pairs.

Top module: `i2s_slave_tx`

## Requirements
- R1: While reset is asserted, `sdata` is 0. After reset, `sdata` stays 0 until the first word-select transition has been detected.
- R2: A word-select level change is sampled on a rising `mclk` edge. Slot 0 of the new half-frame begins on the third rising edge from that one, which is two edges later. Every detected transition restarts the bit divider and the slot count, even when the previous half-frame was shorter or longer than 32 slots.
- R3: Each slot lasts 4 `mclk` cycles when `ratio_sel` is 0 (256 times the sample rate) and 2 cycles when `ratio_sel` is 1 (128 times the sample rate). `sdata` changes only at slot boundaries.
- R4: Slot 0 of each half-frame carries 0. Slot k, for k from 1 to 24, carries word bit 24-k, so bit 23 goes out in slot 1 and bit 0 in slot 24.
- R5: Slots 25 to 31 carry 0. A half-frame that runs past 32 slots stays in slot 31 and keeps sending 0 until the next transition.
- R6: While the sampled word-select level is 0 the left word is sent, and while it is 1 the right word is sent.
- R7: A strobe on `smp_valid` stores `smp_left` and `smp_right` as a pending pair. The pending pair moves into the transmit holding register only when a falling word-select transition is detected. A strobe in that same cycle loads the new words directly. Until then, the words being sent do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word-select clock from the external master; low = left, high = right |
| ratio_sel | input | 1 | 0: master clock is 256 times the sample rate; 1: master clock is 128 times the sample rate |
| smp_valid | input | 1 | One-cycle strobe that marks a new stereo pair |
| smp_left | input | 24 | Left word offered with the strobe |
| smp_right | input | 24 | Right word offered with the strobe |
| sdata | output | 1 | Serial data, MSB first, changes at slot boundaries |

## Verification
The bench sets half-frames that are too short, too long and of nominal length.

- A short half-frame tests R2. A divider that does not restart on each transition would slide the most significant bit into the wrong slot.
- A long half-frame tests R5. A slot count that wraps instead of holding would send a second copy of the word.
- A new pair is offered in the middle of a left half to test R7. Loading it at once would send a right word from a different pair than the left word beside it.
- Both ratio settings are run (R3). The all-ones word, the single-end-bit words and alternating patterns expose slot offsets by one and reversed bit order.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  // Master-clock cycles per bit slot for a given ratio select.
  function automatic int slot_cycles(input logic sel, input int wide, input int narrow);
    return sel ? narrow : wide;
  endfunction

endpackage

// File: rtl/i2s_lr_sync.sv
module i2s_lr_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_in,
  output logic lr_level,
  output logic lr_edge
);
  logic [SYNC_N:0] lr_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lr_pipe <= '0;
    else        lr_pipe <= {lr_pipe[SYNC_N-1:0], lr_in};
  end

  assign lr_level = lr_pipe[SYNC_N-1];
  assign lr_edge  = lr_pipe[SYNC_N-1] ^ lr_pipe[SYNC_N];
endmodule

// File: rtl/i2s_bit_timer.sv
module i2s_bit_timer #(
  parameter int SLOT_N = 32,
  parameter int DIV_W  = 2,
  localparam int SLOT_W = $clog2(SLOT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DIV_W-1:0]  div_max,
  output logic [DIV_W-1:0]  div_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_next,
  output logic              bit_tick
);
  logic [DIV_W-1:0] div_next;
  logic             wrap;

  always_comb begin
    wrap     = (div_q >= div_max);
    bit_tick = wrap && !restart;
    if (restart) begin
      div_next  = '0;
      slot_next = '0;
    end else begin
      div_next  = wrap ? '0 : div_q + DIV_W'(1);
      slot_next = (wrap && slot_q != SLOT_W'(SLOT_N - 1)) ? slot_q + SLOT_W'(1) : slot_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= '0;
    end else begin
      div_q  <= div_next;
      slot_q <= slot_next;
    end
  end
endmodule

// File: rtl/i2s_pair_hold.sv
module i2s_pair_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] in_l,
  input  logic [WORD_W-1:0] in_r,
  input  logic              load,
  output logic [WORD_W-1:0] hold_l,
  output logic [WORD_W-1:0] hold_r
);
  logic [WORD_W-1:0] pend_l, pend_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
      hold_l <= '0;
      hold_r <= '0;
    end else begin
      if (valid) begin
        pend_l <= in_l;
        pend_r <= in_r;
      end
      if (load) begin
        hold_l <= valid ? in_l : pend_l;
        hold_r <= valid ? in_r : pend_r;
      end
    end
  end
endmodule

// File: rtl/i2s_slave_tx.sv
module i2s_slave_tx #(
  parameter int WORD_W     = 24,
  parameter int SLOT_N     = 32,
  parameter int DIV_WIDE   = 4,
  parameter int DIV_NARROW = 2,
  parameter int SYNC_N     = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              ratio_sel,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  output logic              sdata
);
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int DIV_W  = (DIV_WIDE > 1) ? $clog2(DIV_WIDE) : 1;

  // Bit carried by a slot: zero lead slot, word MSB-first, zero tail.
  function automatic logic slot_bit(input logic [WORD_W-1:0] w, input logic [SLOT_W-1:0] s);
    int k;
    k = int'(s);
    if (k >= 1 && k <= WORD_W) return w[WORD_W-k];
    return 1'b0;
  endfunction

  logic              lr_level, lr_edge, lr_fall;
  logic [DIV_W-1:0]  div_max, div_q;
  logic [SLOT_W-1:0] slot_q, slot_next;
  logic              bit_tick;
  logic [WORD_W-1:0] hold_l, hold_r;
  logic              chan_q, chan_next;
  logic              locked_q, locked_next;
  logic              sdata_q;

  assign div_max = DIV_W'(i2s_tx_pkg::slot_cycles(ratio_sel, DIV_WIDE, DIV_NARROW) - 1);
  assign lr_fall = lr_edge && !lr_level;

  i2s_lr_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(mclk), .rst_n(rst_n), .lr_in(lrclk),
    .lr_level(lr_level), .lr_edge(lr_edge)
  );

  i2s_bit_timer #(.SLOT_N(SLOT_N), .DIV_W(DIV_W)) u_timer (
    .clk(mclk), .rst_n(rst_n), .restart(lr_edge), .div_max(div_max),
    .div_q(div_q), .slot_q(slot_q), .slot_next(slot_next), .bit_tick(bit_tick)
  );

  i2s_pair_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(mclk), .rst_n(rst_n), .valid(smp_valid), .in_l(smp_left), .in_r(smp_right),
    .load(lr_fall), .hold_l(hold_l), .hold_r(hold_r)
  );

  always_comb begin
    chan_next   = lr_edge ? lr_level : chan_q;
    locked_next = locked_q | lr_edge;
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q   <= 1'b0;
      locked_q <= 1'b0;
      sdata_q  <= 1'b0;
    end else begin
      chan_q   <= chan_next;
      locked_q <= locked_next;
      sdata_q  <= locked_next && slot_bit(chan_next ? hold_r : hold_l, slot_next);
    end
  end

  assign sdata = sdata_q;
endmodule

// File: rtl/i2s_slave_tx_chk.sv
module i2s_slave_tx_chk #(
  parameter int WORD_W = 24,
  parameter int SLOT_W = 5,
  parameter int DIV_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdata,
  input logic              lr_edge,
  input logic              lr_level,
  input logic              bit_tick,
  input logic [SLOT_W-1:0] slot_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              locked,
  input logic [WORD_W-1:0] hold_l,
  input logic [WORD_W-1:0] hold_r
);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !locked |-> !sdata);
  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_edge |=> (slot_q == '0 && div_q == '0 && locked));
  // R3
  bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lr_edge && !bit_tick) |=> $stable(sdata));
  // R4
  lead_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && slot_q == '0) |-> !sdata);
  // R5
  tail_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(slot_q) > WORD_W) |-> !sdata);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lr_edge && !lr_level) |=> $stable({hold_l, hold_r}));
endmodule

bind i2s_slave_tx i2s_slave_tx_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .DIV_W(DIV_W)) u_chk (
  .clk(mclk), .rst_n(rst_n), .sdata(sdata), .lr_edge(lr_edge), .lr_level(lr_level),
  .bit_tick(bit_tick), .slot_q(slot_q), .div_q(div_q), .locked(locked_q),
  .hold_l(hold_l), .hold_r(hold_r)
);

// File: tb/i2s_slave_tx_tb.sv
module i2s_slave_tx_tb;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lrclk = 1'b0;
  logic        ratio_sel = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic        sdata;

  int    checks = 0, failures = 0;
  bit    done = 0;
  string phase_tag = "";

  always #2.5 mclk = ~mclk;

  i2s_slave_tx u_dut (
    .mclk(mclk), .rst_n(rst_n), .lrclk(lrclk), .ratio_sel(ratio_sel),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right), .sdata(sdata)
  );

  // Behavioural reference: level history, age since half-frame start, words.
  logic        h1, h2, h3;
  int          age;
  bit          m_locked, m_chan;
  logic [23:0] pend_l, pend_r, hold_l, hold_r;
  logic        exp_sd;
  int          m_slot;

  always @(posedge mclk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; age = 0; m_locked = 0; m_chan = 0;
      pend_l = 0; pend_r = 0; hold_l = 0; hold_r = 0;
    end else begin
      if (h2 != h3) begin
        age = 0; m_locked = 1; m_chan = h2;
        if (!h2) begin
          hold_l = smp_valid ? smp_left : pend_l;
          hold_r = smp_valid ? smp_right : pend_r;
        end
      end else if (age < 1000000) age++;
      if (smp_valid) begin pend_l = smp_left; pend_r = smp_right; end
      h3 = h2; h2 = h1; h1 = lrclk;
    end
    m_slot = age / (ratio_sel ? 2 : 4);
    if (m_slot > 31) m_slot = 31;
    if (!m_locked) exp_sd = 0;
    else if (m_slot >= 1 && m_slot <= 24) exp_sd = m_chan ? hold_r[24-m_slot] : hold_l[24-m_slot];
    else exp_sd = 0;
  end

  function automatic string cls_tag();
    if (phase_tag != "") return phase_tag;
    if (!m_locked) return "R1";
    if (m_slot == 0) return "R4";
    if (m_slot > 24) return "R5";
    return m_chan ? "R6" : "R4";
  endfunction

  always @(negedge mclk) begin
    if (!done) begin
      checks++;
      if (sdata !== exp_sd) begin
        failures++;
        $display("FAIL %s t=%0t slot=%0d chan=%0d actual=%b expected=%b",
                 cls_tag(), $time, m_slot, m_chan, sdata, exp_sd);
      end
    end
  end

  task automatic half(input logic lv, input int n);
    @(negedge mclk) lrclk = lv;
    repeat (n - 1) @(negedge mclk);
  endtask

  task automatic offer(input logic [23:0] l, input logic [23:0] r);
    @(negedge mclk); smp_valid = 1; smp_left = l; smp_right = r;
    @(negedge mclk); smp_valid = 0;
  endtask

  task automatic frame(input int n);
    half(1'b0, n); half(1'b1, n);
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge mclk);
    checks++;
    if (sdata !== 1'b0) begin failures++; $display("FAIL R1 reset actual=%b expected=0", sdata); end
    rst_n = 1;
    phase_tag = "R1";
    repeat (20) @(negedge mclk);
    phase_tag = "";
    offer(24'hA5C3F1, 24'h800001);
    half(1'b1, 128);                 // right half before any load: zeros
    frame(128);                      // R4 R6 nominal 256x frame
    // R7: new pair arrives mid left half; right half must keep old word
    @(negedge mclk) lrclk = 0;
    repeat (40) @(negedge mclk);
    phase_tag = "R7";
    offer(24'hFFFFFF, 24'h7FFFFE);
    repeat (86) @(negedge mclk);
    half(1'b1, 128);
    phase_tag = "";
    frame(128);
    // R2: irregular half-frames force restarts
    phase_tag = "R2";
    offer(24'h123456, 24'h654321);
    half(1'b0, 100); half(1'b1, 60); half(1'b0, 128); half(1'b1, 37);
    // R5: overlong half-frame saturates at the last slot
    phase_tag = "R5";
    half(1'b0, 200); half(1'b1, 300);
    phase_tag = "";
    half(1'b0, 128);
    // R3: 128x ratio after a fresh reset
    @(negedge mclk) rst_n = 0; ratio_sel = 1; lrclk = 0;
    repeat (3) @(negedge mclk);
    rst_n = 1;
    phase_tag = "R3";
    offer(24'h800001, 24'hA5C3F1);
    half(1'b1, 64);
    frame(64);
    offer(24'h5AA55A, 24'h0F0F0F);
    frame(64); frame(64);
    half(1'b0, 40); half(1'b1, 64); half(1'b0, 64);
    phase_tag = "";
    done = 1;
    @(negedge mclk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule